// File: doc/BRIEF.md
# SPI Flash Page-Program Sequencer

This block programs a run of bytes into a serial NOR flash. A host gives it a start pulse with a 24-bit target address and a byte length, then feeds the data bytes over a valid/ready stream. The sequencer splits the run into program bursts, and no burst crosses a 256-byte page. Before each burst it waits for the device to finish any earlier internal operation. It then obtains a confirmed write-enable and sends one program frame.

The block does not shift bits itself. It drives chip select and hands single bytes to an external byte-level SPI shifter using a request/done handshake. The response byte comes back with the done strobe. When the last burst has been issued, the sequencer waits for the device to go idle. It then pulses done and presents the number of data bytes it programmed.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, cs_n is high, and sh_req, busy, done and in_ready are low. byte_count reads 0.
- R2: A status frame is opcode 0x05 followed by one 0xFF filler byte. The second response byte is the status, with bit 0 meaning the device is busy. Before each burst, and before completion, status frames repeat until bit 0 reads 0. No write-enable or program opcode is sent while the device is busy.
- R3: Write-enable is opcode 0x06 alone in its own frame. It is followed by a status frame, and the pair repeats until status bit 1 (write enabled) reads 1. A program opcode is sent only after such a confirmation.
- R4: A program frame is opcode 0x02, then the address in three bytes with the most significant byte first, then the data bytes. All of these fall under one low period of cs_n. Each burst starts at the address that follows the last byte of the previous burst.
- R5: A burst ends after the byte whose address has low 8 bits equal to 0xFF. The number of program frames equals the number of 256-byte pages the run touches.
- R6: A burst also ends when the remaining length reaches zero, and the total number of data bytes sent equals the length.
- R7: Data bytes are taken from the input stream in order, one per cycle in which in_valid and in_ready are both high. Byte i is written to the start address plus i. in_ready is high only inside a program frame, and the block waits while in_valid is low.
- R8: After the last burst, the block polls status until the device is not busy. It then raises done for exactly one cycle, with busy low and byte_count equal to the length.
- R9: A zero length produces only status polling followed by done, with no write-enable and no program frame.
- R10: At most one byte exchange is outstanding at a time. sh_req occurs only while cs_n is low, and cs_n rises only when no exchange is outstanding.
- R11: A start pulse while busy is ignored and does not change the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only when idle |
| start_addr | input | 24 | First flash address of the run |
| length | input | 16 | Number of bytes to program |
| in_data | input | 8 | Host data byte |
| in_valid | input | 1 | Host data byte available |
| in_ready | output | 1 | Sequencer takes the byte this cycle when in_valid is high |
| cs_n | output | 1 | Flash chip select, active low |
| sh_req | output | 1 | One-cycle request to exchange sh_tx |
| sh_tx | output | 8 | Byte to shift out |
| sh_done | input | 1 | Shifter finished the outstanding exchange |
| sh_rx | input | 8 | Byte shifted in, valid with sh_done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| byte_count | output | 16 | Data bytes programmed in the current or last run |

## Verification
The assertions take for granted that the shifter raises sh_done only after a request and never in the same cycle as sh_req. They also assume that start, length and the data stream follow the handshake, with no in_valid glitches mattering outside in_ready. The bench's flash responder answers each request two cycles later with a one-cycle sh_done and never issues a spurious strobe. It reports busy for a few polls after every program frame and ignores the first write-enable of each burst, so both retry loops run. The host stream drops in_valid on a fixed cadence, and start pulses are sent only while idle, apart from the deliberate R11 probe.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] FILLER    = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE,
    S_POLL_OP,
    S_POLL_DUM,
    S_POLL_CHK,
    S_WEN,
    S_WEL_OP,
    S_WEL_DUM,
    S_WEL_CHK,
    S_PRG_OP,
    S_PRG_ADR,
    S_PRG_DAT,
    S_FIN
  } seq_state_t;

endpackage

// File: rtl/fps_xfer.sv
// Single-exchange byte port toward the SPI shifter.
module fps_xfer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [BYTE_W-1:0] go_byte,
  output logic              sh_req,
  output logic [BYTE_W-1:0] sh_tx,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] sh_rx,
  output logic              idle,
  output logic              fin,
  output logic [BYTE_W-1:0] rx_last
);

  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      sh_req  <= 1'b0;
      sh_tx   <= '0;
      rx_last <= '0;
    end else begin
      sh_req <= 1'b0;
      if (go && !pend) begin
        pend   <= 1'b1;
        sh_req <= 1'b1;
        sh_tx  <= go_byte;
      end else if (pend && sh_done) begin
        pend    <= 1'b0;
        rx_last <= sh_rx;
      end
    end
  end

  assign idle = !pend;
  assign fin  = pend && sh_done;

endmodule

// File: rtl/fps_cursor.sv
// Address and remaining-length tracker with page-end detection.
module fps_cursor #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  remain,
  output logic              burst_last,
  output logic              empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= ld_addr;
      remain <= ld_len;
    end else if (step) begin
      addr   <= addr + ADDR_W'(1);
      remain <= remain - LEN_W'(1);
    end
  end

  assign burst_last = (remain == LEN_W'(1)) || (&addr[PAGE_W-1:0]);
  assign empty      = (remain == '0);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int          ADDR_W    = 24,
  parameter int          LEN_W     = 16,
  parameter int          PAGE_W    = 8,
  parameter logic [7:0]  BUSY_MASK = 8'h01,
  parameter logic [7:0]  WEL_MASK  = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              cs_n,
  output logic              sh_req,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  byte_count
);
  import fps_pkg::*;

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  seq_state_t        state;
  logic [AB_W-1:0]   abyte;
  logic              last_q;
  logic              go;
  logic [7:0]        go_byte;
  logic              idle;
  logic              fin;
  logic [7:0]        rx_last;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_remain;
  logic              burst_last;
  logic              empty;
  logic              dev_busy;
  logic              dev_wel;

  fps_xfer #(.BYTE_W(8)) u_xfer (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .go_byte (go_byte),
    .sh_req  (sh_req),
    .sh_tx   (sh_tx),
    .sh_done (sh_done),
    .sh_rx   (sh_rx),
    .idle    (idle),
    .fin     (fin),
    .rx_last (rx_last)
  );

  fps_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_cursor (
    .clk        (clk),
    .rst        (rst),
    .load       ((state == S_IDLE) && start),
    .ld_addr    (start_addr),
    .ld_len     (length),
    .step       ((state == S_PRG_DAT) && go),
    .addr       (cur_addr),
    .remain     (cur_remain),
    .burst_last (burst_last),
    .empty      (empty)
  );

  assign dev_busy = |(rx_last & BUSY_MASK);
  assign dev_wel  = |(rx_last & WEL_MASK);
  assign in_ready = (state == S_PRG_DAT) && idle;
  assign busy     = (state != S_IDLE);

  always_comb begin
    go      = 1'b0;
    go_byte = FILLER;
    case (state)
      S_POLL_OP, S_WEL_OP: begin
        go      = idle;
        go_byte = OP_STATUS;
      end
      S_POLL_DUM, S_WEL_DUM: begin
        go      = idle;
        go_byte = FILLER;
      end
      S_WEN: begin
        go      = idle;
        go_byte = OP_WREN;
      end
      S_PRG_OP: begin
        go      = idle;
        go_byte = OP_PROG;
      end
      S_PRG_ADR: begin
        go      = idle;
        go_byte = 8'(cur_addr >> {abyte, 3'b000});
      end
      S_PRG_DAT: begin
        go      = idle && in_valid;
        go_byte = in_data;
      end
      default: begin
        go      = 1'b0;
        go_byte = FILLER;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cs_n       <= 1'b1;
      done       <= 1'b0;
      byte_count <= '0;
      abyte      <= '0;
      last_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) cs_n <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            byte_count <= '0;
            state      <= S_POLL_OP;
          end
        end
        S_POLL_OP:  if (fin) state <= S_POLL_DUM;
        S_POLL_DUM: begin
          if (fin) begin
            cs_n  <= 1'b1;
            state <= S_POLL_CHK;
          end
        end
        S_POLL_CHK: begin
          if (dev_busy)   state <= S_POLL_OP;
          else if (empty) state <= S_FIN;
          else            state <= S_WEN;
        end
        S_WEN: begin
          if (fin) begin
            cs_n  <= 1'b1;
            state <= S_WEL_OP;
          end
        end
        S_WEL_OP:  if (fin) state <= S_WEL_DUM;
        S_WEL_DUM: begin
          if (fin) begin
            cs_n  <= 1'b1;
            state <= S_WEL_CHK;
          end
        end
        S_WEL_CHK: state <= dev_wel ? S_PRG_OP : S_WEN;
        S_PRG_OP: begin
          if (fin) begin
            abyte <= AB_W'(ADDR_BYTES - 1);
            state <= S_PRG_ADR;
          end
        end
        S_PRG_ADR: begin
          if (fin) begin
            if (abyte == '0) state <= S_PRG_DAT;
            else             abyte <= abyte - AB_W'(1);
          end
        end
        S_PRG_DAT: begin
          if (go) begin
            last_q     <= burst_last;
            byte_count <= byte_count + LEN_W'(1);
          end
          if (fin && last_q) begin
            cs_n  <= 1'b1;
            state <= S_POLL_OP;
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] length,
  input logic             in_ready,
  input logic             cs_n,
  input logic             sh_req,
  input logic             sh_done,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] byte_count
);

  logic             out_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      len_q <= '0;
    end else begin
      if (sh_req)       out_q <= 1'b1;
      else if (sh_done) out_q <= 1'b0;
      if (start && !busy) len_q <= length;
    end
  end

  // R10
  xfer_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sh_req |-> !cs_n);

  // R10
  single_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    sh_req |-> !out_q);

  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !out_q);

  // R7
  data_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !cs_n);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (byte_count == len_q));

endmodule

bind flash_prog_seq fps_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;

  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam int PAGE_W = 8;
  localparam int PAGE   = 1 << PAGE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [LEN_W-1:0]  length = '0;
  logic [7:0]        in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              cs_n;
  logic              sh_req;
  logic [7:0]        sh_tx;
  logic              sh_done = 1'b0;
  logic [7:0]        sh_rx = '0;
  logic              busy;
  logic              done;
  logic [LEN_W-1:0]  byte_count;

  always #5 clk = ~clk;

  flash_prog_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .length(length), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cs_n(cs_n), .sh_req(sh_req), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx), .busy(busy), .done(done),
    .byte_count(byte_count)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
  endfunction

  // Flash responder state
  bit                m_in_frame = 1'b0;
  int                m_idx = 0;
  logic [7:0]        m_op = '0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [ADDR_W-1:0] m_next = '0;
  int                m_busy_left = 0;
  bit                m_wel = 1'b0;
  bit                m_skip = 1'b1;
  int                m_len = 0;
  int                m_prog_frames = 0;
  int                m_wren_frames = 0;
  int                m_data_bytes = 0;
  int                m_cnt = 0;
  logic [7:0]        m_rx = '0;

  task automatic end_frame();
    int nb, lo, room, left, expb;
    if (m_op == 8'h02) begin
      nb   = m_idx - 4;
      lo   = int'(m_addr[PAGE_W-1:0]);
      room = PAGE - lo;
      left = m_len - (m_data_bytes - nb);
      expb = (room < left) ? room : left;
      // R5 R6: burst cut at page end or at end of length
      check(nb == expb, "R5/R6", "burst length", nb, expb);
      m_prog_frames++;
      m_next      = m_addr + ADDR_W'(nb);
      m_wel       = 1'b0;
      m_busy_left = 2;
      m_skip      = 1'b1;
    end
  endtask

  task automatic take_byte(input logic [7:0] b, output logic [7:0] rx);
    int k;
    logic [ADDR_W-1:0] a;
    rx = 8'hFF;
    if (m_idx == 0) begin
      m_op = b;
      if (b == 8'h06) begin
        m_wren_frames++;
        // R2: no write-enable while busy
        check(m_busy_left == 0, "R2", "wren while busy", m_busy_left, 0);
        if (m_skip) m_skip = 1'b0;
        else        m_wel  = 1'b1;
      end else if (b == 8'h02) begin
        // R3: program opcode only with WEL set; R2: device idle
        check(m_wel, "R3", "WEL at program opcode", m_wel, 1);
        check(m_busy_left == 0, "R2", "program while busy", m_busy_left, 0);
      end else begin
        // R2: only status, wren or program opcodes
        check(b == 8'h05, "R2", "opcode", b, 8'h05);
      end
    end else if (m_op == 8'h05) begin
      check(m_idx == 1 && b == 8'hFF, "R2", "status filler", b, 8'hFF);
      rx = {6'b0, m_wel, (m_busy_left > 0)};
      if (m_busy_left > 0) m_busy_left--;
    end else if (m_op == 8'h06) begin
      check(1'b0, "R3", "extra byte in wren frame", m_idx, 0);
    end else if (m_op == 8'h02) begin
      if (m_idx <= 3) begin
        m_addr = {m_addr[ADDR_W-9:0], b};
        // R4: address MSB first, contiguous with previous burst
        if (m_idx == 3) check(m_addr == m_next, "R4", "burst address", m_addr, m_next);
      end else begin
        k = m_idx - 4;
        a = m_addr + ADDR_W'(k);
        // R5: never wraps inside a page
        check(int'(m_addr[PAGE_W-1:0]) + k < PAGE, "R5", "page wrap", k, PAGE);
        // R7: data order
        check(b == pat(a), "R7", "data byte", b, pat(a));
        m_data_bytes++;
      end
    end
    m_idx++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sh_done) sh_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          sh_done = 1'b1;
          sh_rx   = m_rx;
        end
      end
      if (!rst) begin
        if (cs_n) begin
          if (m_in_frame) end_frame();
          m_in_frame = 1'b0;
          m_idx      = 0;
        end else if (sh_req) begin
          m_in_frame = 1'b1;
          take_byte(sh_tx, m_rx);
          m_cnt = 2;
        end
      end
    end
  end

  task automatic run_case(input logic [ADDR_W-1:0] addr, input int len,
                          input bit probe);
    int  idx, cyc, pages;
    bit  hs, got;
    m_busy_left   = 1;
    m_wel         = 1'b0;
    m_skip        = 1'b1;
    m_len         = len;
    m_next        = addr;
    m_prog_frames = 0;
    m_wren_frames = 0;
    m_data_bytes  = 0;
    @(negedge clk);
    start      = 1'b1;
    start_addr = addr;
    length     = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    idx = 0; cyc = 0; hs = 1'b0; got = 1'b0;
    while (!got && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (hs) idx++;
      in_valid = (idx < len) && (cyc % 7 != 3);
      in_data  = pat(addr + ADDR_W'(idx));
      hs       = in_valid && in_ready;
      if (probe && cyc == 40) begin
        // R11: restart attempt while busy
        start      = 1'b1;
        start_addr = addr ^ 24'h000F0F;
        length     = 16'd5;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        got = 1'b1;
        check(byte_count == LEN_W'(len), probe ? "R11" : "R8", "byte_count", byte_count, len);
        check(!busy, "R8", "busy at done", busy, 0);
      end
    end
    in_valid = 1'b0;
    start    = 1'b0;
    pages = (len == 0) ? 0 : (((int'(addr) + len - 1) >> PAGE_W) - (int'(addr) >> PAGE_W) + 1);
    check(got, "R8", "done seen", got, 1);
    check(idx == len, "R7", "stream bytes taken", idx, len);
    check(m_data_bytes == len, "R6", "bytes programmed", m_data_bytes, len);
    check(m_prog_frames == pages, "R5", "program frames", m_prog_frames, pages);
    check(m_wren_frames == 2 * pages, "R3", "wren frames with retry", m_wren_frames, 2 * pages);
    check(m_busy_left == 0, "R8", "device idle at done", m_busy_left, 0);
    @(negedge clk);
    check(cs_n && !done, "R10", "cs high, done low after run", {cs_n, done}, 2'b10);
    if (len == 0) begin
      // R9: zero length issues no write-enable or program frame
      check(m_wren_frames == 0 && m_prog_frames == 0, "R9", "frames for zero length",
            m_wren_frames + m_prog_frames, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] addrs [4];
    int                lens  [8];
    addrs = '{24'h0000F0, 24'h0001FF, 24'h000100, 24'hABCD7E};
    lens  = '{0, 1, 2, 16, 17, 255, 256, 300};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(cs_n, "R1", "cs_n", cs_n, 1);
    check(!sh_req && !busy && !done && !in_ready, "R1", "control outputs",
          {sh_req, busy, done, in_ready}, 0);
    check(byte_count == '0, "R1", "byte_count", byte_count, 0);
    for (int a = 0; a < 4; a++) begin
      for (int l = 0; l < 8; l++) begin
        run_case(addrs[a], lens[l], 1'b0);
      end
    end
    run_case(24'h0001FF, 17, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule